// File: doc/BRIEF.md
# Privilege-Aware Record Qualifier

This stage sits in front of a control-transfer history buffer. For each retired control-transfer event it decides whether the event may be logged. It also decides whether the source or target address must be hidden because that side ran in a mode where recording is inhibited. Each event arrives with:

- a 4-bit kind;
- both addresses;
- the privilege level and virtualization flag of the mode it leaves and of the mode it enters;
- the machine and guest-supervisor control words;
- the history-freeze status.

The decision is registered. One cycle after an event the stage raises a single-cycle accept strobe together with the addresses to store (possibly zeroed), the event kind, and the return-stack-emulation flag of the governing control word. The buffer uses that flag to turn returns into pops and swaps into overwrites.

Traps get special handling. A trap out of an inhibited mode into an enabled mode is logged with its source hidden. A trap from an enabled mode into an inhibited mode (an external trap) is logged only when the destination side has opted in through trap-enable bits. Such a trap then has its target hidden and skips kind filtering.

Top module: `priv_rec_qual`

## Requirements
- R1: `accept_o` is high exactly in the cycle after a `valid_i` cycle whose event qualifies. It is low otherwise, and low out of reset. When it is high, `src_pc_o`, `tgt_pc_o`, `type_o` and `ras_o` describe that event.
- R2: Each mode's control word is chosen as follows:
  - Machine mode (privilege 3) uses `m_ctl_i`.
  - Supervisor (1) and user (0) use `vs_ctl_i` when their virtualization flag is set, and `m_ctl_i` otherwise.
  - The mode enable is bit 2 for machine, bit 1 for supervisor and bit 0 for user, taken from that word.
- R3: An event is dropped when the source and target modes are both disabled, or when `frozen_i` is set.
- R4: When bit 7 (return-stack emulation) of the target word is set, only these kinds are kept: 8 indirect call, 9 direct call, 12 co-routine swap and 13 return. `ras_o` carries that bit.
- R5: An exception (kind 1) or interrupt (kind 2) leaving a disabled source mode is qualified with source address 0.
- R6: An exception or interrupt from an enabled source into a disabled target is an external trap. If its trap-enable check passes, it is kept with target address 0 and is not subject to the kind filter.
- R7: The trap-enable check works as follows:
  - A virtualized supervisor is first treated as user (source first; the target only when the source was not converted).
  - A virtualized user source requires bit 8 of `vs_ctl_i`.
  - A user source with a non-user target requires bit 8 of `m_ctl_i`.
  - Reaching machine mode from user or supervisor requires bit 9 of `m_ctl_i`.
- R8: An external trap whose trap-enable check fails is dropped.
- R9: A trap return (kind 3) from a disabled source mode is dropped. A trap return into a disabled target mode is kept with target address 0.
- R10: The kind filter applies unless emulation is on or the event is an external trap. Bit 32+kind of the target word set drops the event.
- R11: For the not-taken branch (kind 4), bit 36 of the target word is an enable. When the filter applies, a clear bit drops the event and a set bit keeps it.
- R12: With emulation on, the four kept kinds ignore their filter bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Event present this cycle |
| type_i | input | 4 | Event kind |
| src_pc_i | input | PC_W | Source address |
| tgt_pc_i | input | PC_W | Target address |
| src_prv_i | input | 2 | Source privilege (0 U, 1 S, 3 M) |
| src_virt_i | input | 1 | Source virtualized |
| tgt_prv_i | input | 2 | Target privilege |
| tgt_virt_i | input | 1 | Target virtualized |
| m_ctl_i | input | INH_BASE+16 | Machine control word |
| vs_ctl_i | input | INH_BASE+16 | Guest-supervisor control word |
| frozen_i | input | 1 | History frozen |
| accept_o | output | 1 | Record strobe |
| src_pc_o | output | PC_W | Source address to store |
| tgt_pc_o | output | PC_W | Target address to store |
| type_o | output | 4 | Kind to store |
| ras_o | output | 1 | Emulation flag of target word |

## Verification
The assertions check the following on every cycle:
- no accept without an event;
- freeze always wins;
- the emulation flag never accompanies a filtered-out kind;
- a trap return out of a disabled mode never produces a record;
- a hidden source or target is always zero when a trap is accepted across an enable boundary.

Only the bench scenarios show the rest. That includes the trap-enable decision for each pairing of user, supervisor, machine and their virtual forms, the inverted meaning of the not-taken-branch bit, and control-word selection under virtualization. It also covers the filter bypass for external traps and emulated kinds. The bench compares each of these against a reference model over random control words and privilege pairs.

// File: rtl/prq_pkg.sv
package prq_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int unsigned RAS_BIT = 7;
  localparam int unsigned STE_BIT = 8;
  localparam int unsigned MTE_BIT = 9;

  localparam logic [3:0] EV_EXC   = 4'd1;
  localparam logic [3:0] EV_INT   = 4'd2;
  localparam logic [3:0] EV_TRET  = 4'd3;
  localparam logic [3:0] EV_BR_NT = 4'd4;
  localparam logic [3:0] EV_BR_T  = 4'd5;
  localparam logic [3:0] EV_ICALL = 4'd8;
  localparam logic [3:0] EV_DCALL = 4'd9;
  localparam logic [3:0] EV_IJMP  = 4'd10;
  localparam logic [3:0] EV_DJMP  = 4'd11;
  localparam logic [3:0] EV_SWAP  = 4'd12;
  localparam logic [3:0] EV_RET   = 4'd13;

  function automatic logic ras_kind(input logic [3:0] t);
    return (t == EV_ICALL) || (t == EV_DCALL) || (t == EV_SWAP) || (t == EV_RET);
  endfunction

  function automatic logic mode_en(input logic [1:0] p, input logic [2:0] f);
    case (p)
      PRV_M:   return f[2];
      PRV_S:   return f[1];
      PRV_U:   return f[0];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/prq_mode_sel.sv
module prq_mode_sel
  import prq_pkg::*;
#(
  parameter int unsigned CTL_W = 48
) (
  input  logic [1:0]       src_prv_i,
  input  logic             src_virt_i,
  input  logic [1:0]       tgt_prv_i,
  input  logic             tgt_virt_i,
  input  logic [CTL_W-1:0] m_ctl_i,
  input  logic [CTL_W-1:0] vs_ctl_i,
  output logic             s_en_o,
  output logic             t_en_o,
  output logic [CTL_W-1:0] t_ctl_o
);
  logic [2:0] s_fld;

  // guest word only for virtualized S/U
  assign s_fld   = (src_virt_i && src_prv_i != PRV_M) ? vs_ctl_i[2:0] : m_ctl_i[2:0];
  assign t_ctl_o = (tgt_virt_i && tgt_prv_i != PRV_M) ? vs_ctl_i : m_ctl_i;
  assign s_en_o  = mode_en(src_prv_i, s_fld);
  assign t_en_o  = mode_en(tgt_prv_i, t_ctl_o[2:0]);
endmodule

// File: rtl/prq_xte.sv
module prq_xte
  import prq_pkg::*;
(
  input  logic [1:0] src_prv_i,
  input  logic       src_virt_i,
  input  logic [1:0] tgt_prv_i,
  input  logic       tgt_virt_i,
  input  logic       m_ste_i,
  input  logic       m_mte_i,
  input  logic       vs_ste_i,
  output logic       ok_o
);
  logic [1:0] s_p, t_p;

  always_comb begin
    s_p = src_prv_i;
    t_p = tgt_prv_i;
    // fold VS onto U, source side first
    if (src_virt_i && s_p == PRV_S)      s_p = PRV_U;
    else if (tgt_virt_i && t_p == PRV_S) t_p = PRV_U;
    ok_o = 1'b1;
    if (src_virt_i && s_p == PRV_U) ok_o = ok_o & vs_ste_i;
    if (s_p == PRV_U && t_p != PRV_U) ok_o = ok_o & m_ste_i;
    if ((s_p == PRV_U && t_p != PRV_U && t_p != PRV_S) ||
        (s_p == PRV_S && t_p != PRV_S))
      ok_o = ok_o & m_mte_i;
  end
endmodule

// File: rtl/prq_type_filter.sv
module prq_type_filter
  import prq_pkg::*;
(
  input  logic [15:0] inh_i,
  input  logic [3:0]  type_i,
  output logic        pass_o
);
  logic hit;
  assign hit    = inh_i[type_i];
  // not-taken branch bit is an enable, all others inhibit
  assign pass_o = (type_i == EV_BR_NT) ? hit : !hit;
endmodule

// File: rtl/priv_rec_qual.sv
module priv_rec_qual
  import prq_pkg::*;
#(
  parameter  int unsigned PC_W     = 32,
  parameter  int unsigned INH_BASE = 32,
  localparam int unsigned CTL_W    = INH_BASE + 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       type_i,
  input  logic [PC_W-1:0]  src_pc_i,
  input  logic [PC_W-1:0]  tgt_pc_i,
  input  logic [1:0]       src_prv_i,
  input  logic             src_virt_i,
  input  logic [1:0]       tgt_prv_i,
  input  logic             tgt_virt_i,
  input  logic [CTL_W-1:0] m_ctl_i,
  input  logic [CTL_W-1:0] vs_ctl_i,
  input  logic             frozen_i,
  output logic             accept_o,
  output logic [PC_W-1:0]  src_pc_o,
  output logic [PC_W-1:0]  tgt_pc_o,
  output logic [3:0]       type_o,
  output logic             ras_o
);
  logic             s_en, t_en, xte_ok, filt_pass;
  logic [CTL_W-1:0] t_ctl;
  logic             ras, is_trap, is_tret;
  logic             keep, src_z, tgt_z, ext;
  logic             unused_ctl;

  assign unused_ctl = ^{m_ctl_i, vs_ctl_i};

  prq_mode_sel #(.CTL_W(CTL_W)) u_mode (
    .src_prv_i (src_prv_i),
    .src_virt_i(src_virt_i),
    .tgt_prv_i (tgt_prv_i),
    .tgt_virt_i(tgt_virt_i),
    .m_ctl_i   (m_ctl_i),
    .vs_ctl_i  (vs_ctl_i),
    .s_en_o    (s_en),
    .t_en_o    (t_en),
    .t_ctl_o   (t_ctl)
  );

  prq_xte u_xte (
    .src_prv_i (src_prv_i),
    .src_virt_i(src_virt_i),
    .tgt_prv_i (tgt_prv_i),
    .tgt_virt_i(tgt_virt_i),
    .m_ste_i   (m_ctl_i[STE_BIT]),
    .m_mte_i   (m_ctl_i[MTE_BIT]),
    .vs_ste_i  (vs_ctl_i[STE_BIT]),
    .ok_o      (xte_ok)
  );

  prq_type_filter u_filt (
    .inh_i (t_ctl[INH_BASE +: 16]),
    .type_i(type_i),
    .pass_o(filt_pass)
  );

  assign ras     = t_ctl[RAS_BIT];
  assign is_trap = (type_i == EV_EXC) || (type_i == EV_INT);
  assign is_tret = (type_i == EV_TRET);

  always_comb begin
    keep  = valid_i;
    src_z = 1'b0;
    tgt_z = 1'b0;
    ext   = 1'b0;
    if ((!s_en && !t_en) || frozen_i) keep = 1'b0;
    if (ras && !ras_kind(type_i))     keep = 1'b0;
    if (is_trap) begin
      if (!s_en) src_z = 1'b1;
      else if (!t_en) begin
        ext   = 1'b1;
        tgt_z = 1'b1;
        if (!xte_ok) keep = 1'b0;
      end
    end else if (is_tret) begin
      if (!s_en) keep  = 1'b0;
      if (!t_en) tgt_z = 1'b1;
    end
    if (!ras && !ext && !filt_pass) keep = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      src_pc_o <= '0;
      tgt_pc_o <= '0;
      type_o   <= '0;
      ras_o    <= 1'b0;
    end else begin
      accept_o <= keep;
      if (keep) begin
        src_pc_o <= src_z ? '0 : src_pc_i;
        tgt_pc_o <= tgt_z ? '0 : tgt_pc_i;
        type_o   <= type_i;
        ras_o    <= ras;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !accept_o); // R1
  AST_FROZEN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && frozen_i) |=> !accept_o); // R3
  AST_RAS_KINDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && ras_o) |-> (type_o == EV_ICALL || type_o == EV_DCALL ||
                             type_o == EV_SWAP  || type_o == EV_RET)); // R4
  AST_TRAP_SRC_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_trap && !s_en) |=> (!accept_o || src_pc_o == '0)); // R5
  AST_EXT_TGT_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_trap && s_en && !t_en) |=> (!accept_o || tgt_pc_o == '0)); // R6
  AST_TRET_INH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_tret && !s_en) |=> !accept_o); // R9
endmodule

// File: tb/sim_priv_rec_qual.sv
module sim_priv_rec_qual;
  localparam int unsigned PW = 32;
  localparam int unsigned CW = 48;

  typedef struct packed {
    logic          acc;
    logic [PW-1:0] s;
    logic [PW-1:0] t;
  } res_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [3:0]    ty = '0;
  logic [PW-1:0] spc = '0, tpc = '0;
  logic [1:0]    sprv = '0, tprv = '0;
  logic          svirt = 1'b0, tvirt = 1'b0, frz = 1'b0;
  logic [CW-1:0] mctl = '0, vctl = '0;
  logic          acc_o, ras_o;
  logic [PW-1:0] spc_o, tpc_o;
  logic [3:0]    ty_o;
  int            n_chk = 0, n_fail = 0;
  logic          done = 1'b0;

  always #5 clk = ~clk;

  priv_rec_qual #(.PC_W(PW), .INH_BASE(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .type_i(ty),
    .src_pc_i(spc), .tgt_pc_i(tpc), .src_prv_i(sprv), .src_virt_i(svirt),
    .tgt_prv_i(tprv), .tgt_virt_i(tvirt), .m_ctl_i(mctl), .vs_ctl_i(vctl),
    .frozen_i(frz), .accept_o(acc_o), .src_pc_o(spc_o), .tgt_pc_o(tpc_o),
    .type_o(ty_o), .ras_o(ras_o)
  );

  function automatic logic [CW-1:0] mk(input logic [2:0] en, input logic ras,
                                       input logic ste, input logic mte, input logic [15:0] inh);
    return {inh, 22'd0, mte, ste, ras, 4'd0, en};
  endfunction

  function automatic int ebit(input logic [1:0] p);
    return (p == 2'd3) ? 2 : int'(p);
  endfunction

  function automatic res_t model(input logic [3:0] k, input logic [PW-1:0] sp, input logic [PW-1:0] tp,
                                 input logic [1:0] a, input logic av, input logic [1:0] b, input logic bv,
                                 input logic [CW-1:0] mc, input logic [CW-1:0] vc, input logic fz);
    res_t r;
    logic [CW-1:0] sc, tc;
    logic se, te, ras, ext, ok;
    logic [1:0] x, y;
    r.acc = 1'b0; r.s = sp; r.t = tp;
    sc = (av && a != 2'd3) ? vc : mc;
    tc = (bv && b != 2'd3) ? vc : mc;
    se = sc[ebit(a)];
    te = tc[ebit(b)];
    if ((!se && !te) || fz) return r;
    ras = tc[7];
    if (ras && !(k == 8 || k == 9 || k == 12 || k == 13)) return r;
    ext = 1'b0;
    if (k == 1 || k == 2) begin
      if (!se) r.s = '0;
      else if (!te) begin
        x = a; y = b;
        if (av && x == 2'd1) x = 2'd0;
        else if (bv && y == 2'd1) y = 2'd0;
        ok = 1'b1;
        if (av && x == 2'd0) ok = ok & vc[8];
        if (x == 2'd0 && y != 2'd0) begin
          ok = ok & mc[8];
          if (y != 2'd1) ok = ok & mc[9];
        end else if (x == 2'd1 && y != 2'd1) ok = ok & mc[9];
        if (!ok) return r;
        ext = 1'b1;
        r.t = '0;
      end
    end else if (k == 3) begin
      if (!se) return r;
      if (!te) r.t = '0;
    end
    if (!ras && !ext) begin
      if (k == 4 ? !tc[32+k] : tc[32+k]) return r;
    end
    r.acc = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // caller sits at a negedge; drive, wait one edge, sample at next negedge
  task automatic ev(input string tag, input logic [3:0] k, input logic [1:0] a, input logic av,
                    input logic [1:0] b, input logic bv, input logic [CW-1:0] mc,
                    input logic [CW-1:0] vc, input logic fz,
                    input logic e_acc, input logic [PW-1:0] e_s, input logic [PW-1:0] e_t);
    valid = 1'b1; ty = k; sprv = a; svirt = av; tprv = b; tvirt = bv;
    mctl = mc; vctl = vc; frz = fz;
    @(negedge clk);
    check({tag, " accept"}, {31'd0, acc_o}, {31'd0, e_acc});
    if (e_acc) begin
      check({tag, " src"}, spc_o, e_s);
      check({tag, " tgt"}, tpc_o, e_t);
      check({tag, " kind"}, {28'd0, ty_o}, {28'd0, k});
    end
  endtask

  localparam logic [PW-1:0] SP = 32'h1000_0040;
  localparam logic [PW-1:0] TP = 32'h2000_0080;

  initial begin
    void'($urandom(32'd20231));
    spc = SP; tpc = TP;
    repeat (3) @(negedge clk);
    check("R1 reset accept", {31'd0, acc_o}, 32'd0);
    check("R1 reset src", spc_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 control-word selection
    ev("R2 guest word", 4'd11, 2'd1, 1, 2'd1, 1, mk(3'b000,0,0,0,0), mk(3'b010,0,0,0,0), 0, 1, SP, TP);
    ev("R2 machine word", 4'd11, 2'd1, 0, 2'd1, 0, mk(3'b010,0,0,0,0), mk(3'b000,0,0,0,0), 0, 1, SP, TP);
    ev("R2 virt ignores m", 4'd11, 2'd1, 1, 2'd1, 1, mk(3'b010,0,0,0,0), mk(3'b000,0,0,0,0), 0, 0, SP, TP);
    // R3
    ev("R3 both off", 4'd11, 2'd0, 0, 2'd0, 0, mk(3'b100,0,0,0,0), '0, 0, 0, SP, TP);
    ev("R3 frozen", 4'd11, 2'd1, 0, 2'd1, 0, mk(3'b010,0,0,0,0), '0, 1, 0, SP, TP);
    // R4 / R12
    ev("R4 ras drops branch", 4'd5, 2'd3, 0, 2'd3, 0, mk(3'b100,1,0,0,0), '0, 0, 0, SP, TP);
    ev("R12 ras keeps call", 4'd8, 2'd3, 0, 2'd3, 0, mk(3'b100,1,0,0,16'hFFFF), '0, 0, 1, SP, TP);
    check("R4 ras flag", {31'd0, ras_o}, 32'd1);
    // R5
    ev("R5 src hidden", 4'd1, 2'd0, 0, 2'd3, 0, mk(3'b100,0,0,0,0), '0, 0, 1, 32'd0, TP);
    // R6 / R8 / R7
    ev("R6 ext trap", 4'd1, 2'd1, 0, 2'd3, 0, mk(3'b010,0,0,1,16'h0002), '0, 0, 1, SP, 32'd0);
    check("R6 ras flag clear", {31'd0, ras_o}, 32'd0);
    ev("R8 ext no mte", 4'd1, 2'd1, 0, 2'd3, 0, mk(3'b010,0,0,0,0), '0, 0, 0, SP, TP);
    ev("R7 U->M needs mte", 4'd2, 2'd0, 0, 2'd3, 0, mk(3'b001,0,1,0,0), '0, 0, 0, SP, TP);
    ev("R7 U->M ste+mte", 4'd2, 2'd0, 0, 2'd3, 0, mk(3'b001,0,1,1,0), '0, 0, 1, SP, 32'd0);
    ev("R7 U->S ste only", 4'd2, 2'd0, 0, 2'd1, 0, mk(3'b001,0,1,0,0), '0, 0, 1, SP, 32'd0);
    ev("R7 U->S no ste", 4'd2, 2'd0, 0, 2'd1, 0, mk(3'b001,0,0,1,0), '0, 0, 0, SP, TP);
    ev("R7 VU->VS no vste", 4'd1, 2'd0, 1, 2'd1, 1, mk(3'b000,0,1,1,0), mk(3'b001,0,0,0,0), 0, 0, SP, TP);
    ev("R7 VU->VS vste", 4'd1, 2'd0, 1, 2'd1, 1, mk(3'b000,0,0,0,0), mk(3'b001,0,1,0,0), 0, 1, SP, 32'd0);
    // R9
    ev("R9 tret inhibited src", 4'd3, 2'd3, 0, 2'd0, 0, mk(3'b001,0,0,0,0), '0, 0, 0, SP, TP);
    ev("R9 tret into inhibited", 4'd3, 2'd3, 0, 2'd0, 0, mk(3'b100,0,0,0,0), '0, 0, 1, SP, 32'd0);
    // R10 / R11
    ev("R10 inhibited kind", 4'd9, 2'd3, 0, 2'd3, 0, mk(3'b100,0,0,0,16'h0200), '0, 0, 0, SP, TP);
    ev("R10 permitted kind", 4'd9, 2'd3, 0, 2'd3, 0, mk(3'b100,0,0,0,16'h0000), '0, 0, 1, SP, TP);
    ev("R11 nt branch off", 4'd4, 2'd3, 0, 2'd3, 0, mk(3'b100,0,0,0,16'h0000), '0, 0, 0, SP, TP);
    ev("R11 nt branch on", 4'd4, 2'd3, 0, 2'd3, 0, mk(3'b100,0,0,0,16'h0010), '0, 0, 1, SP, TP);
    // R1 idle: qualifying inputs but no valid
    valid = 1'b0;
    @(negedge clk);
    check("R1 idle", {31'd0, acc_o}, 32'd0);
    // random sweep against model
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] a, b;
      logic av, bv, fz;
      logic [3:0] k;
      logic [CW-1:0] mc, vc;
      res_t e;
      a = ($urandom % 3 == 0) ? 2'd3 : 2'($urandom % 2);
      b = ($urandom % 3 == 0) ? 2'd3 : 2'($urandom % 2);
      av = (a != 2'd3) && $urandom[0];
      bv = (b != 2'd3) && $urandom[0];
      fz = ($urandom % 8 == 0);
      k  = 4'($urandom);
      mc = {16'($urandom), $urandom};
      vc = {16'($urandom), $urandom};
      if ($urandom % 4 != 0) begin mc[7] = 1'b0; vc[7] = 1'b0; end
      spc = $urandom; tpc = $urandom;
      e = model(k, spc, tpc, a, av, b, bv, mc, vc, fz);
      ev("RND", k, a, av, b, bv, mc, vc, fz, e.acc, e.s, e.t);
    end
    valid = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule